// File: doc/BRIEF.md
# Debug Access Authorization Gate

This block sits between an external debug controller and one hart and decides, cycle by cycle, whether a debug request may act on that hart. Two enables control this: a machine-level debug enable input and a submachine enable bit from the hart's security configuration. The gate combines them with the hart's current privilege to decide whether the hart is debuggable. A halt request that arrives while the hart is not debuggable is never lost. It is held as pending and granted in the first cycle in which the hart becomes debuggable. A trigger hit that would enter Debug Mode is suppressed while the hart is not debuggable.

On entering Debug Mode, the gate captures the hart's privilege and virtualization state as the debug access privilege. Abstract memory commands run at that privilege. The debugger may later rewrite the privilege, but only to values that the enables permit. An illegal value is refused with a sticky security fault code. While that code is set, neither commands nor privilege writes take effect. The gate also reports the privilege used for register access without halting. It forces the address-translation select of memory commands to virtual when machine debug is disabled. The relaxed-permission status bit always reads as zero.

Privilege is encoded in 2 bits: 0 user, 1 supervisor, 3 machine. Value 2 is reserved.

Top module: `dbg_access_gate`

## Requirements
- R1: After reset, no halt is pending, the gate is not in Debug Mode, the status readback `acs_rdata_o` is 0, and the debug access privilege is machine (3) with virtualization 0.
- R2: With the machine enable at 1 and the hart in machine mode, a pending halt raises `halt_go_o` in the cycle after the request. Debug Mode is entered at the following clock edge, and the pending flag clears at that edge.
- R3: With the machine enable at 0 and the hart in machine mode, a halt request stays pending for as long as that holds, with `halt_go_o` at 0. In the same state `trig_fire_o` stays 0 when a trigger hits.
- R4: With the hart in user or supervisor mode, the hart is debuggable exactly when the submachine enable or the machine enable is 1. When it is debuggable and not in Debug Mode, `trig_fire_o` follows `trig_hit_i`.
- R5: A pending halt is granted (`halt_go_o`=1) in the first cycle in which the hart becomes debuggable. This happens either when the hart leaves machine mode or when the machine enable rises.
- R6: On entry to Debug Mode, the debug access privilege and virtualization bit are loaded from the hart's privilege and virtualization inputs, as sampled at the entry edge.
- R7: With the machine enable at 1, a privilege write in Debug Mode of user (0), supervisor (1) or machine (3) is accepted and leaves the error code at 0.
- R8: With the machine enable at 0 and the submachine enable at 1, a write of user or supervisor is accepted. A write of machine (3) or of reserved value 2 is rejected: it sets the error code to 6 and leaves the stored privilege and virtualization unchanged.
- R9: The error code is sticky and clears only under a write-one-to-clear through `acs_wr_i`, with bit i of `acs_wdata_i[2:0]` clearing bit i. While the code is nonzero, `cmd_go_o` stays 0 and privilege writes have no effect.
- R10: Register access without halting is allowed with machine privilege (3) when the machine enable is 1. It is allowed with supervisor privilege (1) when only the submachine enable is 1. It is refused when both are 0.
- R11: Status readback is `{relaxed, error[2:0]}`. The relaxed-permission bit (bit 3) reads 0 and ignores writes of 1.
- R12: A memory command starts (`cmd_go_o`) only in Debug Mode with no error pending, and carries the stored debug access privilege. Its virtual-select output is forced to 1 when the machine enable is 0, and passes `cmd_virt_i` through otherwise.
- R13: With both enables at 0, the hart is not debuggable in any mode: halts stay pending and triggers are suppressed in user and supervisor mode as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_dbg_en_i | input | 1 | Machine-level debug enable for this hart |
| s_dbg_en_i | input | 1 | Submachine debug enable configuration bit |
| hart_prv_i | input | 2 | Hart's current privilege (0 U, 1 S, 3 M) |
| hart_virt_i | input | 1 | Hart's current virtualization state |
| halt_req_i | input | 1 | Halt request pulse from the debugger |
| resume_i | input | 1 | Leave Debug Mode |
| trig_hit_i | input | 1 | A Debug-Mode trigger matched in the hart |
| dap_wr_i | input | 1 | Write of the debug access privilege |
| dap_wr_prv_i | input | 2 | Privilege value to write |
| dap_wr_virt_i | input | 1 | Virtualization value to write |
| cmd_valid_i | input | 1 | Abstract memory command request |
| cmd_virt_i | input | 1 | Requested virtual-address select |
| acs_wr_i | input | 1 | Write to the abstract command status |
| acs_wdata_i | input | 4 | Status write data: bit 3 relaxed, bits 2:0 error clear mask |
| halt_pend_o | output | 1 | A halt request is being held |
| halt_go_o | output | 1 | Halt granted this cycle |
| dbg_mode_o | output | 1 | Hart is in Debug Mode |
| trig_fire_o | output | 1 | Trigger allowed to fire |
| dap_prv_o | output | 2 | Stored debug access privilege |
| dap_virt_o | output | 1 | Stored debug access virtualization bit |
| cmd_go_o | output | 1 | Memory command started |
| cmd_virt_o | output | 1 | Virtual-address select to apply |
| cmd_prv_o | output | 2 | Privilege the command uses |
| cmd_v_o | output | 1 | Virtualization the command uses |
| acs_rdata_o | output | 4 | Status readback: relaxed bit and error code |
| nh_allow_o | output | 1 | Register access without halting is allowed |
| nh_prv_o | output | 2 | Privilege of register access without halting |

## Verification
A stuck or wrongly cleared pending flag shows up at the port. It either fails to assert `halt_go_o` in the first debuggable cycle, or asserts it a cycle early, so a single-cycle sample right after each mode or enable change exposes it. A wrong captured privilege appears on `cmd_prv_o` and `dap_prv_o` one edge after entry. A lost or stuck error code appears on `acs_rdata_o` the cycle after the rejected write or clear, and it also shows as an unexpected `cmd_go_o` value on the next command.

// File: rtl/dbg_access_gate.sv
module dbg_access_gate #(
  parameter int PRV_W         = 2,
  parameter int ERR_W         = 3,
  parameter int ERR_SEC_FAULT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m_dbg_en_i,
  input  logic             s_dbg_en_i,
  input  logic [PRV_W-1:0] hart_prv_i,
  input  logic             hart_virt_i,
  input  logic             halt_req_i,
  input  logic             resume_i,
  input  logic             trig_hit_i,
  input  logic             dap_wr_i,
  input  logic [PRV_W-1:0] dap_wr_prv_i,
  input  logic             dap_wr_virt_i,
  input  logic             cmd_valid_i,
  input  logic             cmd_virt_i,
  input  logic             acs_wr_i,
  input  logic [ERR_W:0]   acs_wdata_i,
  output logic             halt_pend_o,
  output logic             halt_go_o,
  output logic             dbg_mode_o,
  output logic             trig_fire_o,
  output logic [PRV_W-1:0] dap_prv_o,
  output logic             dap_virt_o,
  output logic             cmd_go_o,
  output logic             cmd_virt_o,
  output logic [PRV_W-1:0] cmd_prv_o,
  output logic             cmd_v_o,
  output logic [ERR_W:0]   acs_rdata_o,
  output logic             nh_allow_o,
  output logic [PRV_W-1:0] nh_prv_o
);

  localparam logic [PRV_W-1:0] PRV_U   = '0;
  localparam logic [PRV_W-1:0] PRV_S   = PRV_W'(1);
  localparam logic [PRV_W-1:0] PRV_M   = '1;
  localparam logic [ERR_W-1:0] ERR_SEC = ERR_W'(ERR_SEC_FAULT);

  logic             halt_pend_q;
  logic             dbg_mode_q;
  logic [PRV_W-1:0] dap_prv_q;
  logic             dap_virt_q;
  logic [ERR_W-1:0] err_q;

  wire in_m     = (hart_prv_i == PRV_M);
  wire any_en   = m_dbg_en_i | s_dbg_en_i;
  wire dbg_ok   = in_m ? m_dbg_en_i : any_en;
  wire err_idle = (err_q == '0);
  wire halt_go  = halt_pend_q & dbg_ok & ~dbg_mode_q;

  wire wr_low   = (dap_wr_prv_i == PRV_U) | (dap_wr_prv_i == PRV_S);
  wire wr_legal = (dap_wr_prv_i == PRV_M) ? m_dbg_en_i : (wr_low & any_en);
  wire wr_take  = dap_wr_i & dbg_mode_q & err_idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_pend_q <= 1'b0;
      dbg_mode_q  <= 1'b0;
    end else if (halt_go) begin
      halt_pend_q <= 1'b0;
      dbg_mode_q  <= 1'b1;
    end else begin
      if (halt_req_i && !dbg_mode_q) halt_pend_q <= 1'b1;
      if (resume_i) dbg_mode_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dap_prv_q  <= PRV_M;
      dap_virt_q <= 1'b0;
    end else if (halt_go) begin
      dap_prv_q  <= hart_prv_i;
      dap_virt_q <= hart_virt_i;
    end else if (wr_take && wr_legal) begin
      dap_prv_q  <= dap_wr_prv_i;
      dap_virt_q <= (dap_wr_prv_i == PRV_M) ? 1'b0 : dap_wr_virt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_q <= '0;
    else if (wr_take && !wr_legal) err_q <= ERR_SEC;
    else if (acs_wr_i)            err_q <= err_q & ~acs_wdata_i[ERR_W-1:0];
  end

  assign halt_pend_o = halt_pend_q;
  assign halt_go_o   = halt_go;
  assign dbg_mode_o  = dbg_mode_q;
  assign trig_fire_o = trig_hit_i & dbg_ok & ~dbg_mode_q;
  assign dap_prv_o   = dap_prv_q;
  assign dap_virt_o  = dap_virt_q;
  assign cmd_go_o    = cmd_valid_i & dbg_mode_q & err_idle;
  assign cmd_virt_o  = m_dbg_en_i ? cmd_virt_i : 1'b1;
  assign cmd_prv_o   = dap_prv_q;
  assign cmd_v_o     = dap_virt_q;
  assign acs_rdata_o = {1'b0, err_q};
  assign nh_allow_o  = any_en;
  assign nh_prv_o    = m_dbg_en_i ? PRV_M : PRV_S;

  assert_pend_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_pend_q && !dbg_ok && !dbg_mode_q) |=> halt_pend_q);

  assert_entry_needs_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_mode_q) |-> $past(halt_pend_q) && !halt_pend_q);

  assert_entry_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_mode_q) |-> (dap_prv_q == $past(hart_prv_i)) && (dap_virt_q == $past(hart_virt_i)));

  assert_m_write_refused_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dap_wr_i && dbg_mode_q && err_idle && !m_dbg_en_i && dap_wr_prv_i == PRV_M)
      |=> (err_q == ERR_SEC) && $stable(dap_prv_q) && $stable(dap_virt_q));

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_idle && !acs_wr_i) |=> $stable(err_q));

  assert_no_cmd_on_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_idle && dap_wr_i && !halt_go) |=> $stable(dap_prv_q));

  assert_relaxed_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acs_wr_i && acs_wdata_i[ERR_W]) |=> !acs_rdata_o[ERR_W]);

endmodule

// File: tb/dbg_access_gate_tb_top.sv
module dbg_access_gate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_en = 0, s_en = 0, hvirt = 0, hreq = 0, resume = 0, thit = 0;
  logic [1:0] hprv = 2'd3;
  logic dwr = 0, dwv = 0, cval = 0, cvirt = 0, awr = 0;
  logic [1:0] dwp = 0;
  logic [3:0] awd = 0;
  logic pend, go, dmode, tfire, dvirt, cgo, cvo, cv, nha;
  logic [1:0] dprv, cprv, nhp;
  logic [3:0] ard;

  int checks = 0, errors = 0;
  bit done = 0;

  dbg_access_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .m_dbg_en_i(m_en), .s_dbg_en_i(s_en),
    .hart_prv_i(hprv), .hart_virt_i(hvirt), .halt_req_i(hreq), .resume_i(resume),
    .trig_hit_i(thit), .dap_wr_i(dwr), .dap_wr_prv_i(dwp), .dap_wr_virt_i(dwv),
    .cmd_valid_i(cval), .cmd_virt_i(cvirt), .acs_wr_i(awr), .acs_wdata_i(awd),
    .halt_pend_o(pend), .halt_go_o(go), .dbg_mode_o(dmode), .trig_fire_o(tfire),
    .dap_prv_o(dprv), .dap_virt_o(dvirt), .cmd_go_o(cgo), .cmd_virt_o(cvo),
    .cmd_prv_o(cprv), .cmd_v_o(cv), .acs_rdata_o(ard), .nh_allow_o(nha), .nh_prv_o(nhp));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic pulse_halt();
    hreq = 1; step(); hreq = 0;
  endtask

  task automatic do_resume();
    resume = 1; step(); resume = 0;
  endtask

  task automatic dap_write(logic [1:0] p, logic v);
    dwr = 1; dwp = p; dwv = v; step(); dwr = 0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend, 0);
    chk("R1 dmode", dmode, 0);
    chk("R1 status", ard, 0);
    chk("R1 dap prv", dprv, 3);
    chk("R1 dap virt", dvirt, 0);
  endtask

  task automatic t_machine_enabled();
    m_en = 1; s_en = 0; hprv = 3; hvirt = 0;
    pulse_halt();
    chk("R2 go", go, 1);
    step();
    chk("R2 dmode", dmode, 1);
    chk("R2 pend cleared", pend, 0);
    chk("R6 dap prv M", dprv, 3);
    dap_write(2'd0, 1'b1);
    chk("R7 write U", dprv, 0);
    chk("R7 write U virt", dvirt, 1);
    dap_write(2'd1, 1'b0);
    chk("R7 write S", dprv, 1);
    dap_write(2'd3, 1'b0);
    chk("R7 write M", dprv, 3);
    chk("R7 no err", ard, 0);
    cval = 1; cvirt = 0; #0;
    chk("R12 virt passes", cvo, 0);
    chk("R12 go", cgo, 1);
    cval = 0;
    do_resume();
    chk("R2 resumed", dmode, 0);
  endtask

  task automatic t_machine_locked();
    m_en = 0; s_en = 0; hprv = 3; thit = 1; #1;
    chk("R3 trig off", tfire, 0);
    thit = 0;
    pulse_halt();
    for (int i = 0; i < 4; i++) begin
      chk("R3 pending", pend, 1);
      chk("R3 no go", go, 0);
      step();
    end
    chk("R3 no dmode", dmode, 0);
    s_en = 1; hvirt = 1; hprv = 1; #1;
    chk("R5 go on leaving M", go, 1);
    step();
    chk("R6 dap prv S", dprv, 1);
    chk("R6 dap virt", dvirt, 1);
    dap_write(2'd3, 1'b0);
    chk("R8 err 6", ard, 6);
    chk("R8 prv kept", dprv, 1);
    chk("R8 virt kept", dvirt, 1);
    cval = 1; #1;
    chk("R9 cmd blocked", cgo, 0);
    cval = 0;
    dap_write(2'd0, 1'b0);
    chk("R9 write ignored", dprv, 1);
    step();
    chk("R9 sticky", ard, 6);
    awr = 1; awd = 4'b0010; step(); awr = 0;
    chk("R9 partial clear", ard, 4);
    awr = 1; awd = 4'b0100; step(); awr = 0;
    chk("R9 cleared", ard, 0);
    cval = 1; cvirt = 0; #1;
    chk("R9 cmd runs", cgo, 1);
    chk("R12 virt forced", cvo, 1);
    chk("R12 cmd prv", cprv, 1);
    chk("R12 cmd v", cv, 1);
    cval = 0;
    dap_write(2'd2, 1'b0);
    chk("R8 reserved refused", ard, 6);
    awr = 1; awd = 4'b0111; step(); awr = 0;
    dap_write(2'd0, 1'b0);
    chk("R8 write U ok", dprv, 0);
    chk("R8 no err", ard, 0);
    do_resume();
    hvirt = 0;
  endtask

  task automatic t_enable_rise();
    m_en = 0; s_en = 1; hprv = 3;
    pulse_halt();
    chk("R3 pend with s only", pend, 1);
    chk("R3 no go s only", go, 0);
    m_en = 1; #1;
    chk("R5 go on enable rise", go, 1);
    step();
    chk("R5 dmode", dmode, 1);
    do_resume();
  endtask

  task automatic t_below_machine();
    m_en = 0; s_en = 0; hprv = 1; thit = 1; #1;
    chk("R13 trig off S", tfire, 0);
    hprv = 0; #1;
    chk("R13 trig off U", tfire, 0);
    thit = 0;
    pulse_halt();
    step();
    chk("R13 pending", pend, 1);
    chk("R13 no dmode", dmode, 0);
    s_en = 1; thit = 1; #1;
    chk("R4 trig via s", tfire, 1);
    chk("R4 go via s", go, 1);
    thit = 0; step(); do_resume();
    s_en = 0; m_en = 1; thit = 1; #1;
    chk("R4 trig via m", tfire, 1);
    thit = 0;
  endtask

  task automatic t_nonhalt();
    m_en = 1; s_en = 0; #1;
    chk("R10 m allow", nha, 1); chk("R10 m prv", nhp, 3);
    m_en = 0; s_en = 1; #1;
    chk("R10 s allow", nha, 1); chk("R10 s prv", nhp, 1);
    s_en = 0; #1;
    chk("R10 refused", nha, 0);
  endtask

  task automatic t_relaxed();
    awr = 1; awd = 4'b1000; step(); awr = 0;
    chk("R11 relaxed zero", ard, 0);
    step();
    chk("R11 still zero", ard[3], 0);
  endtask

  initial begin
    #9; @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_machine_enabled();
    t_machine_locked();
    t_enable_rise();
    t_below_machine();
    t_nonhalt();
    t_relaxed();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule